// File: doc/BRIEF.md
# Clock-Gated Register Bank with Selectable Power Modes

This block holds a small bank of control and status registers that software reads and writes through a simple strobe port, and that hardware may also update through per-register write enables. It models clock gating with an enable-style gate: a register on the gated domain samples new data only while a shared clock enable is high, and otherwise holds its value.

A two-bit power mode mask picks the optimizations. Bit 0 turns on activity-driven gating. An activity flag is raised for every software access and for the cycle after it, and that flag becomes the gated clock enable. Bit 1 splits the bank into two groups. Registers that hardware can write stay on the free-running clock, and registers that only software writes use the gated clock. Each register also has a build-time exclusion flag that keeps it off the gated clock in every mode.

Top module: `csr_pwr_bank`

## Requirements
- R1: Synchronous active-low reset clears every register to 0 and clears `rd_valid` and `act_o`. With mode bit 0 clear, `clk_en_o` reads 1 during reset.
- R2: A write strobe to address `a` (0 to 7) stores `sw_wdata` into register `a`, which shows on `reg_q[a*32 +: 32]` after the next edge. A read strobe gives `rd_valid` = 1 and the register value on `rd_data` one cycle later. With no read strobe, `rd_valid` is 0 in the following cycle.
- R3: With mode bit 0 set, `act_o` is high in any cycle that has a read or write strobe, and in the cycle after it. Otherwise it is low. With mode bit 0 clear, `act_o` stays 0.
- R4: With mode bit 0 clear, `clk_en_o` is 1. With mode bit 0 set, `clk_en_o` equals the activity flag.
- R5: With mode 0 or mode 2, a hardware write to a register that hardware can write (default mask 0x0F: registers 0 to 3) lands on every edge.
- R6: With mode 1, a hardware write to a gated register is dropped while `clk_en_o` is low. It lands while `clk_en_o` is high, which includes the cycle after a software access.
- R7: With mode 3, registers that hardware can write stay on the free clock, so their hardware writes land while the bank is idle.
- R8: A register whose exclusion flag is set (default mask 0x02: register 1) accepts hardware writes in mode 1 while the bank is idle.
- R9: A hardware write enable to a register that hardware cannot write (registers 4 to 7 by default) leaves that register unchanged.
- R10: When software and hardware write the same register in the same cycle, the software value is stored.
- R11: A read returns the last stored value even when that register's enable has been low since the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_mode | input | 2 | Power mask: bit 0 activity gating, bit 1 grouping by access type |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_addr | input | 3 | Register index for the strobe |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | High one cycle after a read strobe |
| hw_we | input | 8 | Per-register hardware write enables |
| hw_wdata | input | 256 | Hardware write data, lane i at bits i*32 |
| reg_q | output | 256 | All register contents, lane i at bits i*32 |
| act_o | output | 1 | Activity flag, live only with mode bit 0 |
| clk_en_o | output | 1 | Enable of the gated domain |

## Verification
A register that wrongly sits on the gated domain shows up on `reg_q` one edge after a hardware write made in an idle cycle, because its lane keeps the old value. A register that wrongly sits on the free domain shows up the same way, because its lane takes a value it should have dropped. A stuck or late activity flag shows at once on `act_o` and `clk_en_o` in the strobe cycle, or one cycle later in the cycle after the access. Corrupted storage reaches `rd_data` one cycle after the read strobe.

// File: rtl/csr_pwr_pkg.sv
// Shared definitions for the clock-gated register bank.
// Assumes a two-bit power mode in which each bit enables one optimization.
package csr_pwr_pkg;
    localparam int MODE_W   = 2;
    localparam int MODE_ACT = 0;   // activity-driven clock enable
    localparam int MODE_GRP = 1;   // group registers by access type
    typedef logic [MODE_W-1:0] pwr_mode_t;
endpackage

// File: rtl/csr_act_gate.sv
// Derives the activity flag and the shared gated-domain clock enable.
// Assumes that software strobes are single-cycle pulses, and that the mode may change in any cycle.
module csr_act_gate
    import csr_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwr_mode_t mode,
    input  logic      sw_wr,
    input  logic      sw_rd,
    output logic      act_o,
    output logic      clk_en_o
);
    logic req;
    logic tail_q;
    logic busy;

    assign req  = sw_wr | sw_rd;
    assign busy = req | tail_q;

    // Remember an access so that activity lasts one more cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tail_q <= 1'b0;
        else        tail_q <= req;
    end

    // Outputs: activity only when bit 0 asks for it; otherwise the enable is always on.
    always_comb begin
        act_o    = mode[MODE_ACT] & busy;
        clk_en_o = mode[MODE_ACT] ? busy : 1'b1;
    end

    // R3: the cycle after an access still shows activity whenever bit 0 is set.
    p_act_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (act_o == mode[MODE_ACT]));
endmodule

// File: rtl/csr_gate_sel.sv
// Picks, for each register, the gated enable or a constant enable.
// Assumes that the access type and exclusion masks are fixed when the bank is built.
module csr_gate_sel
    import csr_pwr_pkg::*;
#(
    parameter int                  NUM_REGS   = 8,
    parameter logic [NUM_REGS-1:0] HW_WR_MASK = '0,
    parameter logic [NUM_REGS-1:0] EXCL_MASK  = '0
) (
    input  pwr_mode_t           mode,
    input  logic                clk_en,
    output logic [NUM_REGS-1:0] reg_en
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        localparam bit HwWr = HW_WR_MASK[i];
        localparam bit Excl = EXCL_MASK[i];
        logic on_gated;
        // Membership: not excluded, and either no grouping or software-only.
        always_comb on_gated = !Excl && (!mode[MODE_GRP] || !HwWr);
        // Enable: follow the gate when on the gated domain, else free-running.
        always_comb reg_en[i] = on_gated ? clk_en : 1'b1;
    end
endmodule

// File: rtl/csr_cell.sv
// One register with an enable-style clock gate model, a software port and an optional hardware port.
// Assumes that software has priority over hardware and that reset acts whatever the enable.
module csr_cell #(
    parameter int DATA_W = 32,
    parameter bit HW_CAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wd,
    input  logic              hw_we,
    input  logic [DATA_W-1:0] hw_wd,
    output logic [DATA_W-1:0] q
);
    // Storage: samples only while its enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= '0;
        else if (en) begin
            if (sw_we)             q <= sw_wd;
            else if (hw_we && HW_CAP) q <= hw_wd;
        end
    end

    // R6: a closed gate holds the value.
    p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    // R10: a software write through an open gate always lands.
    p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sw_we) |=> (q == $past(sw_wd)));

    if (!HW_CAP) begin : g_nocap
        // R9: without a hardware port, only software changes the value.
        p_no_hw_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !sw_we |=> $stable(q));
    end
endmodule

// File: rtl/csr_rd_port.sv
// Registered read port; the read path runs on the free clock and sees all storage.
// Assumes that an index outside the bank reads as zero.
module csr_rd_port #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_REGS*DATA_W-1:0] regs,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rvalid
);
    logic [DATA_W-1:0] sel;

    // Select the addressed lane.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) sel = regs[i*DATA_W +: DATA_W];
    end

    // Capture the data for one cycle after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= sel;
        end
    end
endmodule

// File: rtl/csr_pwr_bank.sv
// Top of the register bank with selectable clock-gating modes.
// Assumes one software access per cycle and a single free clock; gating is modelled by enables.
module csr_pwr_bank
    import csr_pwr_pkg::*;
#(
    parameter int                  NUM_REGS   = 8,
    parameter int                  DATA_W     = 32,
    parameter logic [NUM_REGS-1:0] HW_WR_MASK = 8'h0F,
    parameter logic [NUM_REGS-1:0] EXCL_MASK  = 8'h02,
    localparam int                 ADDR_W     = $clog2(NUM_REGS),
    localparam int                 FLAT_W     = NUM_REGS * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  pwr_mode,
    input  logic               sw_wr,
    input  logic               sw_rd,
    input  logic [ADDR_W-1:0]  sw_addr,
    input  logic [DATA_W-1:0]  sw_wdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    input  logic [NUM_REGS-1:0] hw_we,
    input  logic [FLAT_W-1:0]  hw_wdata,
    output logic [FLAT_W-1:0]  reg_q,
    output logic               act_o,
    output logic               clk_en_o
);
    logic [NUM_REGS-1:0] reg_en;
    logic [NUM_REGS-1:0] sw_we;

    csr_act_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (pwr_mode),
        .sw_wr    (sw_wr),
        .sw_rd    (sw_rd),
        .act_o    (act_o),
        .clk_en_o (clk_en_o)
    );

    csr_gate_sel #(
        .NUM_REGS   (NUM_REGS),
        .HW_WR_MASK (HW_WR_MASK),
        .EXCL_MASK  (EXCL_MASK)
    ) u_sel (
        .mode   (pwr_mode),
        .clk_en (clk_en_o),
        .reg_en (reg_en)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Decode the software write strobe for this register.
        always_comb sw_we[i] = sw_wr && (sw_addr == ADDR_W'(i));

        csr_cell #(
            .DATA_W (DATA_W),
            .HW_CAP (HW_WR_MASK[i])
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (reg_en[i]),
            .sw_we (sw_we[i]),
            .sw_wd (sw_wdata),
            .hw_we (hw_we[i]),
            .hw_wd (hw_wdata[i*DATA_W +: DATA_W]),
            .q     (reg_q[i*DATA_W +: DATA_W])
        );
    end

    csr_rd_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (sw_rd),
        .addr   (sw_addr),
        .regs   (reg_q),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    // R2: each read strobe gives exactly one valid cycle after it.
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd |=> rd_valid);
    p_rvalid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd |=> !rd_valid);
    // R4: the gated domain is always open during a software access.
    p_en_on_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr || sw_rd) |-> clk_en_o);
    // R11: read data reflects storage as it stood at the strobe.
    p_rd_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd |=> (rd_data == $past(reg_q[sw_addr*DATA_W +: DATA_W])));
endmodule

// File: tb/csr_pwr_bank_tb.sv
`timescale 1ns/1ps
module csr_pwr_bank_tb_top;
    localparam int NR = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        pwr_mode = 2'd0;
    logic              sw_wr = 1'b0;
    logic              sw_rd = 1'b0;
    logic [2:0]        sw_addr = '0;
    logic [DW-1:0]     sw_wdata = '0;
    logic [DW-1:0]     rd_data;
    logic              rd_valid;
    logic [NR-1:0]     hw_we = '0;
    logic [NR*DW-1:0]  hw_wdata = '0;
    logic [NR*DW-1:0]  reg_q;
    logic              act_o;
    logic              clk_en_o;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] expq [NR];

    always #2.5 clk = ~clk;

    csr_pwr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
        .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .hw_we(hw_we), .hw_wdata(hw_wdata), .reg_q(reg_q),
        .act_o(act_o), .clk_en_o(clk_en_o)
    );

    // Stimulus table: {register index, data}
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 32'h1000_0001}, {3'd5, 32'hC0FF_EE05}, {3'd1, 32'h0000_FFFF},
        {3'd7, 32'h8765_4321}, {3'd2, 32'h2468_ACE0}, {3'd4, 32'hFFFF_0000},
        {3'd3, 32'h1357_9BDF}, {3'd6, 32'h6666_0606}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane(input int i);
        return reg_q[i*DW +: DW];
    endfunction

    task automatic hw_put(input int i, input logic [DW-1:0] d);
        hw_we[i] = 1'b1;
        hw_wdata[i*DW +: DW] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) expq[i] = '0;
        tick(); tick(); tick();
        // R1: reset state
        for (int i = 0; i < NR; i++) chk("R1 reset reg", lane(i), '0);
        chk("R1 reset rd_valid", 32'(rd_valid), 0);
        chk("R1 reset act_o", 32'(act_o), 0);
        chk("R1 reset clk_en_o", 32'(clk_en_o), 1);
        rst_n = 1'b1;
        tick();

        // R2: table walk in mode 0, write then read back each vector
        for (int v = 0; v < 8; v++) begin
            sw_wr = 1'b1; sw_addr = VEC[v][34:32]; sw_wdata = VEC[v][31:0];
            tick();
            sw_wr = 1'b0;
            expq[VEC[v][34:32]] = VEC[v][31:0];
            chk("R2 write lane", lane(int'(VEC[v][34:32])), VEC[v][31:0]);
            sw_rd = 1'b1;
            tick();
            sw_rd = 1'b0;
            chk("R2 rd_valid", 32'(rd_valid), 1);
            chk("R2 rd_data", rd_data, VEC[v][31:0]);
        end
        tick();
        chk("R2 rd_valid idle", 32'(rd_valid), 0);

        // R3/R4: activity and enable in mode 1
        pwr_mode = 2'd1;
        tick(); tick();
        chk("R3 idle act_o", 32'(act_o), 0);
        chk("R4 idle clk_en_o", 32'(clk_en_o), 0);
        sw_rd = 1'b1; sw_addr = 3'd4;
        #1;
        chk("R3 strobe act_o", 32'(act_o), 1);
        chk("R4 strobe clk_en_o", 32'(clk_en_o), 1);
        tick();
        sw_rd = 1'b0;
        #1;
        chk("R3 tail act_o", 32'(act_o), 1);
        chk("R4 tail clk_en_o", 32'(clk_en_o), 1);
        chk("R11 read sw-only reg", rd_data, expq[4]);
        tick();
        chk("R3 after tail act_o", 32'(act_o), 0);

        // R6: gated hardware write dropped while idle
        hw_put(0, 32'hDEAD_0001);
        tick();
        hw_we = '0;
        chk("R6 idle write dropped", lane(0), expq[0]);
        // R6: lands together with a software access
        hw_put(2, 32'h2222_AAAA); sw_rd = 1'b1; sw_addr = 3'd7;
        tick();
        hw_we = '0; sw_rd = 1'b0;
        expq[2] = 32'h2222_AAAA;
        chk("R6 write with access", lane(2), expq[2]);
        // R6: lands in the cycle after the access
        hw_put(3, 32'h3333_5555);
        tick();
        hw_we = '0;
        expq[3] = 32'h3333_5555;
        chk("R6 write in tail", lane(3), expq[3]);
        tick();

        // R8: excluded register takes idle hardware writes in mode 1
        hw_put(1, 32'h1111_BEEF);
        tick();
        hw_we = '0;
        expq[1] = 32'h1111_BEEF;
        chk("R8 excluded lands", lane(1), expq[1]);

        // R11: read of a gated register after a long closed gate
        tick(); tick();
        sw_rd = 1'b1; sw_addr = 3'd0;
        tick();
        sw_rd = 1'b0;
        chk("R11 held value", rd_data, expq[0]);
        tick(); tick();

        // R7: mode 3 keeps hardware-writable registers on the free clock
        pwr_mode = 2'd3;
        tick(); tick();
        hw_put(0, 32'h0A0A_0A0A);
        tick();
        hw_we = '0;
        expq[0] = 32'h0A0A_0A0A;
        chk("R7 free clock lands", lane(0), expq[0]);

        // R5: mode 2 with an idle bank
        pwr_mode = 2'd2;
        hw_put(3, 32'h3C3C_3C3C);
        #1;
        chk("R5 clk_en_o", 32'(clk_en_o), 1);
        chk("R3 mode2 act_o", 32'(act_o), 0);
        tick();
        hw_we = '0;
        expq[3] = 32'h3C3C_3C3C;
        chk("R5 mode2 lands", lane(3), expq[3]);

        // R5: mode 0 with an idle bank
        pwr_mode = 2'd0;
        hw_put(2, 32'h7777_0002);
        tick();
        hw_we = '0;
        expq[2] = 32'h7777_0002;
        chk("R5 mode0 lands", lane(2), expq[2]);

        // R9: no hardware port on register 6
        hw_put(6, 32'h0000_0BAD);
        tick();
        hw_we = '0;
        chk("R9 ignored", lane(6), expq[6]);

        // R10: software beats hardware
        sw_wr = 1'b1; sw_addr = 3'd2; sw_wdata = 32'h5A5A_5A5A;
        hw_put(2, 32'hA5A5_A5A5);
        #1;
        chk("R3 mode0 act_o", 32'(act_o), 0);
        tick();
        sw_wr = 1'b0; hw_we = '0;
        expq[2] = 32'h5A5A_5A5A;
        chk("R10 software wins", lane(2), expq[2]);

        // R1: reset during operation
        rst_n = 1'b0;
        tick();
        for (int i = 0; i < NR; i++) chk("R1 mid reset reg", lane(i), '0);
        chk("R1 mid reset rd_valid", 32'(rd_valid), 0);
        rst_n = 1'b1;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule